// File: doc/BRIEF.md
# Lockable Flash Controller Register Bank

This block holds the 32-bit software-visible registers of a serial flash controller. Word accesses arrive on a simple strobe bus that decodes a 4 KiB space. The block keeps the configuration for direct reads, direct writes and manual transactions. It stores the command, the address and the transmit words for a manual transaction, and it exports all of them to a separate transaction engine. That engine returns the bytes it receives through a narrow load port, and it signals the end of a transaction with a single-cycle done pulse.

Three configuration words can be frozen by software through a whole-word lock bit. The manual configuration word also has a finer lock that pins only a few fields. The control/status word has fields that behave in different ways. The ready flag is cleared by writing 1 to it. The execute flag starts a transaction and reads 1 until that transaction finishes. A software chip-select force selects or releases a flash device. A release requested while a transfer is running, or in the same write that starts one, takes effect only when the transfer ends, so the select line does not glitch mid-transfer.

Top module: `flash_regbank`

## Requirements
- R1: Registers sit at byte offsets 0x00 read config, 0x04 write config, 0x08 manual config, 0x0C control/status, 0x10 command, 0x14 address, 0x18 protect config, 0x20-0x2C transmit words, 0x30-0x3C receive words, 0x40-0x64 protect commands and 0x78 global config. Read data appears on `bus_rdata_o` one cycle after the read strobe. Any other offset reads zero and ignores writes.
- R2: After reset, manual config reads 0x00000400, control/status 0x00010000, command 0x0000000B, protect config 0x00000400 and global config 0x0000000B. Every other register reads zero and `cs_o` is all zero.
- R3: A write to the read, write or manual config word is dropped whenever bit 31 of that word is already set.
- R4: While bit 30 of the manual config word is set, a write leaves the bits of mask 0x00000403 at their previous values and updates the remaining bits.
- R5: Bus writes to the receive words have no effect. Those words are loaded only by the engine through `rx_we_i`, `rx_idx_i` and `rx_data_i`.
- R6: Control/status keeps only bit 25 (ready interrupt enable), bit 24 (ready), bit 16 (software chip select), bits 9:8 (device number), bit 4 (select error) and bit 0 (execute); all other bits read zero. Writing 1 to bit 24 clears it, and writing 0 leaves it unchanged.
- R7: Writing 1 to bit 0 while no transaction runs raises `start_o` for one cycle. Bit 0 then reads 1 until a `done_i` pulse, which clears it and sets bit 24. A write of 1 to bit 0 while a transaction runs starts nothing.
- R8: A write that clears bit 16 while it was set drives the `cs_o` line numbered by bits 9:8 of the written value, starting the cycle after the write.
- R9: A write that sets bit 16 while it was clear releases the forced select at once, but only if bit 0 is clear both in the old and in the written value. Otherwise the release happens at the `done_i` that ends the transaction.
- R10: `irq_o` is high exactly while both bit 25 and bit 24 are set.
- R11: A select request for a device number not below NUM_CS drives no `cs_o` line. It sets bit 4 and `cs_err_o`, and both stay set until reset.
- R12: A transaction started while bit 16 is set drives the `cs_o` line for the device number written with the start, and keeps it for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | AW | Byte address; the low two bits are ignored |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, registered |
| rd_cfg_o | output | DW | Direct read configuration |
| wr_cfg_o | output | DW | Direct write configuration |
| man_cfg_o | output | DW | Manual transaction configuration |
| cmd_o | output | DW | Manual command word |
| addr_o | output | DW | Manual address word |
| tx_data_o | output | TXW*DW | Transmit words, word 0 in the low bits |
| rx_we_i | input | 1 | Engine load strobe for a receive word |
| rx_idx_i | input | $clog2(RXW) | Receive word index |
| rx_data_i | input | DW | Receive word data |
| start_o | output | 1 | One-cycle transaction start |
| done_i | input | 1 | One-cycle transaction end |
| cs_o | output | NUM_CS | Active-high chip-select requests, at most one set |
| irq_o | output | 1 | Ready interrupt |
| cs_err_o | output | 1 | Sticky invalid-select flag |

## Verification
On every cycle the assertions check these properties: locked configuration bits do not change, bus writes leave the receive words alone, the start pulse lasts one cycle, a done pulse clears execute and sets ready, `cs_o` stays one-hot or zero, a select line stays up through a running transaction, and the select-error flag stays set. The bench scenarios are needed for the actual read-back values. They cover the masked merge of the manual config, the deferred release when the software force is set during a transfer, the write-one-to-clear of ready and its effect on the interrupt, and the choice of device line for forced and transaction selects.

// File: rtl/flash_rb_pkg.sv
package flash_rb_pkg;
   // word indices (byte offset / 4); the decode depends on these positions
   localparam int W_RCFG = 0;
   localparam int W_WCFG = 1;
   localparam int W_MCFG = 2;
   localparam int W_CTRL = 3;
   localparam int W_CMD  = 4;
   localparam int W_ADDR = 5;
   localparam int W_PCFG = 6;
   localparam int W_TX   = 8;
   localparam int W_RX   = 12;
   localparam int W_PCMD = 16;
   localparam int W_GCFG = 30;

   localparam int TX_MAX   = 4;
   localparam int RX_MAX   = 4;
   localparam int PCMD_MAX = 10;

   // lock fields
   localparam int          LOCK_ALL_BIT  = 31;
   localparam int          LOCK_PART_BIT = 30;
   localparam logic [31:0] LOCK_PART_MSK = 32'h0000_0403;

   // control/status fields
   localparam int B_EXEC = 0;
   localparam int B_ERR  = 4;
   localparam int B_DEVL = 8;
   localparam int B_SWCS = 16;
   localparam int B_RDY  = 24;
   localparam int B_IEN  = 25;

   // reset values
   localparam logic [31:0] RST_MCFG = 32'h0000_0400;
   localparam logic [31:0] RST_CMD  = 32'h0000_000B;
   localparam logic [31:0] RST_PCFG = 32'h0000_0400;
   localparam logic [31:0] RST_GCFG = 32'h0000_000B;
endpackage

// File: rtl/flash_rb_lockreg.sv
module flash_rb_lockreg #(
   parameter int          W        = 32,
   parameter logic [W-1:0] RST     = '0,
   parameter bit          PARTIAL  = 1'b0,
   parameter int          ALL_BIT  = 31,
   parameter int          PART_BIT = 30,
   parameter logic [W-1:0] PART_MSK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] merged;

   generate
      if (PARTIAL) begin : g_part
         // pinned fields keep their value while the partial lock is set
         always_comb begin
            if (q[PART_BIT]) merged = (wdata & ~PART_MSK) | (q & PART_MSK);
            else             merged = wdata;
         end
      end else begin : g_plain
         assign merged = wdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   q <= RST;
      else if (we && !q[ALL_BIT])   q <= merged;
   end
endmodule

// File: rtl/flash_rb_store.sv
module flash_rb_store #(
   parameter int           N   = 1,
   parameter int           W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   we,
   input  logic [W-1:0]   wdata,
   output logic [N*W-1:0] q
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[g*W +: W] <= RST;
            else if (we[g]) q[g*W +: W] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/flash_rb_ctrl.sv
module flash_rb_ctrl
   import flash_rb_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DW-1:0]     wdata,
   input  logic              done_i,
   output logic [DW-1:0]     stat_o,
   output logic              start_o,
   output logic [NUM_CS-1:0] cs_o,
   output logic              irq_o,
   output logic              err_o
);
   localparam int DEVW = 2;

   logic            ien, rdy, swcs, err, busy, start_q;
   logic [DEVW-1:0] dev, txn_num, force_num, sel_num;
   logic            force_act, sel_act;
   logic [DEVW-1:0] wdev;
   logic            go, sel_evt, rel_evt, bad_sel, fin, rdy_n;

   assign wdev = wdata[B_DEVL +: DEVW];
   assign fin  = busy && done_i;
   assign go   = we && wdata[B_EXEC] && !busy;
   // force select: software chip-select bit goes from 1 to 0
   assign sel_evt = we && swcs && !wdata[B_SWCS];
   // release only when no transfer runs or is about to start
   assign rel_evt = we && !swcs && wdata[B_SWCS] && !busy && !wdata[B_EXEC];
   assign bad_sel = (sel_evt || (go && wdata[B_SWCS] && !force_act))
                    && (int'(wdev) >= NUM_CS);

   always_comb begin
      rdy_n = rdy;
      if (we && wdata[B_RDY]) rdy_n = 1'b0;
      if (fin)                rdy_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien       <= 1'b0;
         rdy       <= 1'b0;
         swcs      <= 1'b1;
         dev       <= '0;
         err       <= 1'b0;
         busy      <= 1'b0;
         start_q   <= 1'b0;
         force_act <= 1'b0;
         force_num <= '0;
         txn_num   <= '0;
      end else begin
         start_q <= go;
         rdy     <= rdy_n;
         if (we) begin
            ien  <= wdata[B_IEN];
            swcs <= wdata[B_SWCS];
            dev  <= wdev;
         end
         if (fin) begin
            busy <= 1'b0;
         end else if (go) begin
            busy    <= 1'b1;
            txn_num <= wdev;
         end
         if (sel_evt) begin
            force_act <= 1'b1;
            force_num <= wdev;
         end else if (rel_evt || (fin && swcs)) begin
            force_act <= 1'b0;
         end
         if (bad_sel) err <= 1'b1;
      end
   end

   assign sel_act = force_act || (busy && swcs);
   assign sel_num = force_act ? force_num : txn_num;

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
         assign cs_o[g] = sel_act && (int'(sel_num) == g);
      end
   endgenerate

   always_comb begin
      stat_o                  = '0;
      stat_o[B_EXEC]          = busy;
      stat_o[B_ERR]           = err;
      stat_o[B_DEVL +: DEVW]  = dev;
      stat_o[B_SWCS]          = swcs;
      stat_o[B_RDY]           = rdy;
      stat_o[B_IEN]           = ien;
   end

   assign start_o = start_q;
   assign irq_o   = ien && rdy;
   assign err_o   = err;
endmodule

// File: rtl/flash_regbank.sv
module flash_regbank
   import flash_rb_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int AW     = 12,
   parameter int DW     = 32,
   parameter int TXW    = 4,
   parameter int RXW    = 4,
   parameter int PCW    = 10,
   localparam int IDXW  = $clog2(RXW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic [DW-1:0]     bus_wdata_i,
   output logic [DW-1:0]     bus_rdata_o,
   output logic [DW-1:0]     rd_cfg_o,
   output logic [DW-1:0]     wr_cfg_o,
   output logic [DW-1:0]     man_cfg_o,
   output logic [DW-1:0]     cmd_o,
   output logic [DW-1:0]     addr_o,
   output logic [TXW*DW-1:0] tx_data_o,
   input  logic              rx_we_i,
   input  logic [IDXW-1:0]   rx_idx_i,
   input  logic [DW-1:0]     rx_data_i,
   output logic              start_o,
   input  logic              done_i,
   output logic [NUM_CS-1:0] cs_o,
   output logic              irq_o,
   output logic              cs_err_o
);
   generate
      if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
         $error("NUM_CS must lie in 1..4");
      end
      if (DW != 32) begin : g_bad_dw
         $error("DW must be 32");
      end
      if (AW < 7) begin : g_bad_aw
         $error("AW too small for the register map");
      end
      if (TXW < 1 || TXW > TX_MAX || RXW < 2 || RXW > RX_MAX) begin : g_bad_buf
         $error("TXW must lie in 1..4 and RXW in 2..4");
      end
      if (PCW < 1 || PCW > PCMD_MAX) begin : g_bad_pcw
         $error("PCW must lie in 1..10");
      end
   endgenerate

   int widx;
   assign widx = int'(bus_addr_i[AW-1:2]);

   logic              we_rcfg, we_wcfg, we_mcfg, we_ctrl;
   logic [0:0]        we_cmd, we_addr, we_pcfg, we_gcfg;
   logic [TXW-1:0]    we_tx;
   logic [PCW-1:0]    we_pcmd;
   logic [RXW-1:0]    we_rx;
   logic [DW-1:0]     pcfg_q, gcfg_q, stat_q;
   logic [PCW*DW-1:0] pcmd_q;
   logic [RXW*DW-1:0] rx_q;
   logic [DW-1:0]     rd_mux;

   assign we_rcfg    = bus_wr_i && (widx == W_RCFG);
   assign we_wcfg    = bus_wr_i && (widx == W_WCFG);
   assign we_mcfg    = bus_wr_i && (widx == W_MCFG);
   assign we_ctrl    = bus_wr_i && (widx == W_CTRL);
   assign we_cmd[0]  = bus_wr_i && (widx == W_CMD);
   assign we_addr[0] = bus_wr_i && (widx == W_ADDR);
   assign we_pcfg[0] = bus_wr_i && (widx == W_PCFG);
   assign we_gcfg[0] = bus_wr_i && (widx == W_GCFG);

   generate
      for (genvar g = 0; g < TXW; g++) begin : g_we_tx
         assign we_tx[g] = bus_wr_i && (widx == W_TX + g);
      end
      for (genvar g = 0; g < PCW; g++) begin : g_we_pc
         assign we_pcmd[g] = bus_wr_i && (widx == W_PCMD + g);
      end
      // receive words: engine port only, bus writes never reach them
      for (genvar g = 0; g < RXW; g++) begin : g_we_rx
         assign we_rx[g] = rx_we_i && (int'(rx_idx_i) == g);
      end
   endgenerate

   flash_rb_lockreg #(.W(DW), .RST('0), .PARTIAL(1'b0),
      .ALL_BIT(LOCK_ALL_BIT), .PART_BIT(LOCK_PART_BIT), .PART_MSK(LOCK_PART_MSK))
   u_rcfg (.clk(clk), .rst_n(rst_n), .we(we_rcfg), .wdata(bus_wdata_i), .q(rd_cfg_o));

   flash_rb_lockreg #(.W(DW), .RST('0), .PARTIAL(1'b0),
      .ALL_BIT(LOCK_ALL_BIT), .PART_BIT(LOCK_PART_BIT), .PART_MSK(LOCK_PART_MSK))
   u_wcfg (.clk(clk), .rst_n(rst_n), .we(we_wcfg), .wdata(bus_wdata_i), .q(wr_cfg_o));

   flash_rb_lockreg #(.W(DW), .RST(RST_MCFG), .PARTIAL(1'b1),
      .ALL_BIT(LOCK_ALL_BIT), .PART_BIT(LOCK_PART_BIT), .PART_MSK(LOCK_PART_MSK))
   u_mcfg (.clk(clk), .rst_n(rst_n), .we(we_mcfg), .wdata(bus_wdata_i), .q(man_cfg_o));

   flash_rb_store #(.N(1), .W(DW), .RST(RST_CMD))
   u_cmd (.clk(clk), .rst_n(rst_n), .we(we_cmd), .wdata(bus_wdata_i), .q(cmd_o));

   flash_rb_store #(.N(1), .W(DW), .RST('0))
   u_addr (.clk(clk), .rst_n(rst_n), .we(we_addr), .wdata(bus_wdata_i), .q(addr_o));

   flash_rb_store #(.N(1), .W(DW), .RST(RST_PCFG))
   u_pcfg (.clk(clk), .rst_n(rst_n), .we(we_pcfg), .wdata(bus_wdata_i), .q(pcfg_q));

   flash_rb_store #(.N(1), .W(DW), .RST(RST_GCFG))
   u_gcfg (.clk(clk), .rst_n(rst_n), .we(we_gcfg), .wdata(bus_wdata_i), .q(gcfg_q));

   flash_rb_store #(.N(TXW), .W(DW), .RST('0))
   u_tx (.clk(clk), .rst_n(rst_n), .we(we_tx), .wdata(bus_wdata_i), .q(tx_data_o));

   flash_rb_store #(.N(PCW), .W(DW), .RST('0))
   u_pcmd (.clk(clk), .rst_n(rst_n), .we(we_pcmd), .wdata(bus_wdata_i), .q(pcmd_q));

   flash_rb_store #(.N(RXW), .W(DW), .RST('0))
   u_rx (.clk(clk), .rst_n(rst_n), .we(we_rx), .wdata(rx_data_i), .q(rx_q));

   flash_rb_ctrl #(.NUM_CS(NUM_CS), .DW(DW))
   u_ctrl (.clk(clk), .rst_n(rst_n), .we(we_ctrl), .wdata(bus_wdata_i),
           .done_i(done_i), .stat_o(stat_q), .start_o(start_o), .cs_o(cs_o),
           .irq_o(irq_o), .err_o(cs_err_o));

   always_comb begin
      rd_mux = '0;
      unique case (widx)
         W_RCFG:  rd_mux = rd_cfg_o;
         W_WCFG:  rd_mux = wr_cfg_o;
         W_MCFG:  rd_mux = man_cfg_o;
         W_CTRL:  rd_mux = stat_q;
         W_CMD:   rd_mux = cmd_o;
         W_ADDR:  rd_mux = addr_o;
         W_PCFG:  rd_mux = pcfg_q;
         W_GCFG:  rd_mux = gcfg_q;
         default: rd_mux = '0;
      endcase
      for (int i = 0; i < TXW; i++)
         if (widx == W_TX + i) rd_mux = tx_data_o[i*DW +: DW];
      for (int i = 0; i < RXW; i++)
         if (widx == W_RX + i) rd_mux = rx_q[i*DW +: DW];
      for (int i = 0; i < PCW; i++)
         if (widx == W_PCMD + i) rd_mux = pcmd_q[i*DW +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/flash_regbank_chk.sv
module flash_regbank_chk #(
   parameter int NUM_CS = 2,
   parameter int AW     = 12,
   parameter int DW     = 32,
   parameter int RXW    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_i,
   input logic [AW-1:0]     bus_addr_i,
   input logic [DW-1:0]     rd_cfg_o,
   input logic [DW-1:0]     man_cfg_o,
   input logic [DW-1:0]     stat_q,
   input logic [RXW*DW-1:0] rx_q,
   input logic              rx_we_i,
   input logic              start_o,
   input logic              done_i,
   input logic [NUM_CS-1:0] cs_o,
   input logic              cs_err_o
);
   logic wr_rcfg, wr_mcfg, wr_ctrl;
   assign wr_rcfg = bus_wr_i && (int'(bus_addr_i[AW-1:2]) == 0);
   assign wr_mcfg = bus_wr_i && (int'(bus_addr_i[AW-1:2]) == 2);
   assign wr_ctrl = bus_wr_i && (int'(bus_addr_i[AW-1:2]) == 3);

   // R3
   a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rcfg && rd_cfg_o[31]) |=> $stable(rd_cfg_o));

   // R4
   a_r4_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mcfg && man_cfg_o[30]) |=> ((man_cfg_o & 32'h403) == ($past(man_cfg_o) & 32'h403)));

   // R5
   a_r5_rx_readonly: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && !rx_we_i) |=> $stable(rx_q));

   // R7
   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R7
   a_r7_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[0] && done_i) |=> (!stat_q[0] && stat_q[24]));

   // R8
   a_r8_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_o));

   // R9
   a_r9_hold_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[0] && (|cs_o) && !done_i && !wr_ctrl) |=> (|cs_o));

   // R11
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cs_err_o |=> cs_err_o);
endmodule

bind flash_regbank flash_regbank_chk #(
   .NUM_CS(NUM_CS), .AW(AW), .DW(DW), .RXW(RXW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
   .rd_cfg_o(rd_cfg_o), .man_cfg_o(man_cfg_o), .stat_q(stat_q), .rx_q(rx_q),
   .rx_we_i(rx_we_i), .start_o(start_o), .done_i(done_i), .cs_o(cs_o),
   .cs_err_o(cs_err_o)
);

// File: tb/flash_regbank_test.sv
module flash_regbank_test;
   localparam int NUM_CS = 2;
   localparam int AW = 12;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0;
   logic [DW-1:0]     bus_rdata, rd_cfg, wr_cfg, man_cfg, cmd, addr;
   logic [4*DW-1:0]   tx_data;
   logic              rx_we = 1'b0;
   logic [1:0]        rx_idx = '0;
   logic [DW-1:0]     rx_data = '0;
   logic              start, done = 1'b0, irq, cs_err;
   logic [NUM_CS-1:0] cs;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   flash_regbank #(.NUM_CS(NUM_CS), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .rd_cfg_o(rd_cfg), .wr_cfg_o(wr_cfg), .man_cfg_o(man_cfg), .cmd_o(cmd),
      .addr_o(addr), .tx_data_o(tx_data), .rx_we_i(rx_we), .rx_idx_i(rx_idx),
      .rx_data_i(rx_data), .start_o(start), .done_i(done), .cs_o(cs),
      .irq_o(irq), .cs_err_o(cs_err));

   typedef struct packed {
      logic        wr;
      logic [11:0] a;
      logic [31:0] d;
      logic [31:0] e;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 12'h000, 32'h0, 32'h0000_0000, 4'd2},   // R2
      '{1'b0, 12'h004, 32'h0, 32'h0000_0000, 4'd2},   // R2
      '{1'b0, 12'h008, 32'h0, 32'h0000_0400, 4'd2},   // R2
      '{1'b0, 12'h00C, 32'h0, 32'h0001_0000, 4'd2},   // R2
      '{1'b0, 12'h010, 32'h0, 32'h0000_000B, 4'd2},   // R2
      '{1'b0, 12'h018, 32'h0, 32'h0000_0400, 4'd2},   // R2
      '{1'b0, 12'h078, 32'h0, 32'h0000_000B, 4'd2},   // R2
      '{1'b0, 12'h03C, 32'h0, 32'h0000_0000, 4'd2},   // R2
      '{1'b0, 12'h01C, 32'h0, 32'h0000_0000, 4'd1},   // R1 unused
      '{1'b1, 12'h010, 32'h1234_5678, 32'h0, 4'd1},
      '{1'b0, 12'h010, 32'h0, 32'h1234_5678, 4'd1},   // R1
      '{1'b1, 12'h014, 32'h00AB_CDEF, 32'h0, 4'd1},
      '{1'b0, 12'h014, 32'h0, 32'h00AB_CDEF, 4'd1},   // R1
      '{1'b1, 12'h02C, 32'hA5A5_A5A5, 32'h0, 4'd1},
      '{1'b0, 12'h02C, 32'h0, 32'hA5A5_A5A5, 4'd1},   // R1
      '{1'b1, 12'h064, 32'h0F0F_0F0F, 32'h0, 4'd1},
      '{1'b0, 12'h064, 32'h0, 32'h0F0F_0F0F, 4'd1},   // R1
      '{1'b1, 12'h068, 32'hFFFF_FFFF, 32'h0, 4'd1},
      '{1'b0, 12'h068, 32'h0, 32'h0000_0000, 4'd1},   // R1 unused
      '{1'b1, 12'h030, 32'hDEAD_BEEF, 32'h0, 4'd5},
      '{1'b0, 12'h030, 32'h0, 32'h0000_0000, 4'd5},   // R5
      '{1'b1, 12'h000, 32'h8000_00AA, 32'h0, 4'd3},
      '{1'b0, 12'h000, 32'h0, 32'h8000_00AA, 4'd3},   // R3
      '{1'b1, 12'h000, 32'h0000_0011, 32'h0, 4'd3},
      '{1'b0, 12'h000, 32'h0, 32'h8000_00AA, 4'd3},   // R3
      '{1'b1, 12'h008, 32'h4000_0000, 32'h0, 4'd4},
      '{1'b0, 12'h008, 32'h0, 32'h4000_0000, 4'd4},   // R4
      '{1'b1, 12'h008, 32'h0000_FFFF, 32'h0, 4'd4},
      '{1'b0, 12'h008, 32'h0, 32'h0000_FBFC, 4'd4},   // R4
      '{1'b1, 12'h008, 32'h4000_FFFF, 32'h0, 4'd4},
      '{1'b0, 12'h008, 32'h0, 32'h4000_FFFF, 4'd4},   // R4
      '{1'b1, 12'h008, 32'h0000_0000, 32'h0, 4'd4},
      '{1'b0, 12'h008, 32'h0, 32'h0000_0403, 4'd4},   // R4
      '{1'b1, 12'h008, 32'h8000_0000, 32'h0, 4'd3},
      '{1'b0, 12'h008, 32'h0, 32'h8000_0000, 4'd3},   // R3
      '{1'b1, 12'h008, 32'h0000_0005, 32'h0, 4'd3},
      '{1'b0, 12'h008, 32'h0, 32'h8000_0000, 4'd3},   // R3
      '{1'b1, 12'h004, 32'h0300_0002, 32'h0, 4'd1},
      '{1'b0, 12'h004, 32'h0, 32'h0300_0002, 4'd1}    // R1
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(2, 32'(cs), 32'h0);          // R2 no select after reset

      for (int k = 0; k < NV; k++) begin
         if (TBL[k].wr) wr(TBL[k].a, TBL[k].d);
         else begin
            rd(TBL[k].a, v);
            chk(int'(TBL[k].req), v, TBL[k].e);
         end
      end

      // R8 force select device 1
      wr(12'h00C, 32'h0000_0100);
      chk(8, 32'(cs), 32'h2);
      rd(12'h00C, v);
      chk(6, v, 32'h0000_0100);
      // R7 start
      wr(12'h00C, 32'h0000_0101);
      chk(7, 32'(start), 32'h1);
      @(negedge clk);
      chk(7, 32'(start), 32'h0);
      // R9 release requested while busy is deferred; R7 no restart
      wr(12'h00C, 32'h0001_0101);
      chk(7, 32'(start), 32'h0);
      chk(9, 32'(cs), 32'h2);
      rd(12'h00C, v);
      chk(7, v, 32'h0001_0101);
      pulse_done();
      chk(9, 32'(cs), 32'h0);
      rd(12'h00C, v);
      chk(7, v, 32'h0101_0100);
      chk(10, 32'(irq), 32'h0);
      // R6 writing 0 keeps ready; R10 interrupt
      wr(12'h00C, 32'h0201_0100);
      chk(10, 32'(irq), 32'h1);
      rd(12'h00C, v);
      chk(6, v, 32'h0301_0100);
      wr(12'h00C, 32'h0301_0100);
      chk(10, 32'(irq), 32'h0);
      rd(12'h00C, v);
      chk(6, v, 32'h0201_0100);
      // R12 transaction select with software chip select set
      wr(12'h00C, 32'h0201_0001);
      chk(12, 32'(cs), 32'h1);
      chk(7, 32'(start), 32'h1);
      repeat (3) @(negedge clk);
      chk(12, 32'(cs), 32'h1);
      pulse_done();
      chk(12, 32'(cs), 32'h0);
      chk(10, 32'(irq), 32'h1);
      rd(12'h00C, v);
      chk(7, v, 32'h0301_0000);
      // R9 immediate release without transfer
      wr(12'h00C, 32'h0000_0000);
      chk(8, 32'(cs), 32'h1);
      wr(12'h00C, 32'h0001_0000);
      chk(9, 32'(cs), 32'h0);
      // R11 invalid device
      wr(12'h00C, 32'h0000_0300);
      chk(11, 32'(cs), 32'h0);
      chk(11, 32'(cs_err), 32'h1);
      rd(12'h00C, v);
      chk(11, v, 32'h0100_0310);
      wr(12'h00C, 32'h0001_0000);
      rd(12'h00C, v);
      chk(11, v, 32'h0101_0010);
      // R5 engine load and bus write ignored
      @(negedge clk);
      rx_we = 1'b1; rx_idx = 2'd2; rx_data = 32'hCAFE_F00D;
      @(negedge clk);
      rx_we = 1'b0;
      rd(12'h038, v);
      chk(5, v, 32'hCAFE_F00D);
      wr(12'h038, 32'h1111_2222);
      rd(12'h038, v);
      chk(5, v, 32'hCAFE_F00D);
      // R2 reset clears locks and sticky error
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(2, 32'(cs_err), 32'h0);
      rd(12'h000, v);
      chk(2, v, 32'h0);
      rd(12'h008, v);
      chk(2, v, 32'h0000_0400);
      summary();
   end
endmodule